// File: doc/BRIEF.md
# Prime-Factor Index Mapper and Pre-Combiner

This block sits in front of a row-column inverse cosine/sine transform whose length N is split into two coprime factors, N = N1×N2. Software or an upstream stage writes one frame of N signed frequency-domain samples into an internal frame buffer, addressed by their linear index. A frame-start pulse then makes the block walk every coordinate pair (k1,k2) of the N1×N2 grid. For each pair it forms the combined value y(k1,k2) that the two-stage transform expects, one value per clock.

Each pair selects two samples. The selection uses the modular map lin(a,b) = (N2·a + N1·b) mod N, applied to the pair itself or to its mirrored coordinates N1−k1 and N2−k2. The block adds or subtracts the two samples depending on the raw sum N2·k1 + N1·k2. Results leave in column-major order with a valid strobe and their coordinates. While a frame is being emitted the block reports busy, and it ignores both buffer writes and further frame-start pulses. No DC weighting and no scaling are applied: every weight is one.

Top module: `pf_precombiner`

## Requirements
- R1: After a synchronous active-low reset, busy and out_valid are 0, out_data is 0, and every frame-buffer entry reads as zero, so a frame started with no prior writes emits all zeros.
- R2: An accepted frame emits exactly N outputs, one per cycle. The first output appears in the second cycle after frame_start is sampled. The order is column-major: out_k1 counts 0..N1−1 fastest, then out_k2 advances through 0..N2−1.
- R3: With X[i] the sample last written at linear address i, when N2·k1 + N1·k2 < N the output is X[lin(k1,k2)] − X[lin(N1−k1, N2−k2)].
- R4: When N2·k1 + N1·k2 ≥ N (equality included), the output is X[lin(N1−k1, k2)] + X[lin(k1, N2−k2)].
- R5: A mirrored coordinate equal to N1 or to N2 makes that operand a zero sample, whatever the buffer holds.
- R6: frame_start sampled while idle sets busy in the next cycle. busy clears in the same cycle the last output is presented. frame_start sampled while busy has no effect.
- R7: wr_en sampled while busy does not change the buffer. A write sampled in the same cycle as an accepted frame_start is stored and used by that frame.
- R8: Samples are two's complement of width DW, and out_data is DW+1 bits wide. Sums and differences of extreme values (for example 127+127 and −128−127 at DW=8) appear exactly, without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Pulse to begin emitting the stored frame |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | clog2(N) | Linear index of the sample written |
| wr_data | input | DW | Signed sample value |
| busy | output | 1 | High while a frame is being emitted |
| out_valid | output | 1 | out_data, out_k1 and out_k2 are valid |
| out_k1 | output | clog2(N1) | First coordinate of the current output |
| out_k2 | output | clog2(N2) | Second coordinate of the current output |
| out_data | output | DW+1 | Signed combined value y(k1,k2) |

## Verification
The sample-write port and the emission read path can be active in the same cycle, in two ways. The bench writes new values into the buffer while a frame is being emitted and repeats frame_start during emission. It then checks that the rest of that frame and the next frame still carry the old values. It also raises wr_en together with an accepted frame_start and checks that the frame uses the new sample. A cycle-level reference model in the bench applies the same acceptance rules and compares busy, out_valid, the coordinates and the data on every clock.

// File: rtl/pf_pkg.sv
// Package pf_pkg
// Shared types and constant helpers for the prime-factor pre-combiner.
// Assumes nothing about the factor values beyond being positive.
package pf_pkg;

    // Which combining rule applies to a grid point
    typedef enum logic {
        BR_DIFF = 1'b0,
        BR_SUM  = 1'b1
    } pf_branch_e;

    // Bit count needed to hold 0..n-1, at least one bit
    function automatic int pf_bits(input int n);
        int b;
        b = 1;
        while ((1 << b) < n) b = b + 1;
        return b;
    endfunction

endpackage

// File: rtl/pf_coord_counter.sv
// Module pf_coord_counter
// Walks the N1 x N2 grid in column-major order: k1 fastest, then k2.
// Assumes clear and advance are never needed in the same cycle with
// conflicting intent; clear wins.
module pf_coord_counter #(
    parameter int N1  = 3,
    parameter int N2  = 4,
    parameter int K1W = 2,
    parameter int K2W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    output logic [K1W-1:0] k1,
    output logic [K2W-1:0] k2,
    output logic           last
);

    localparam logic [K1W-1:0] K1_MAX = K1W'(N1 - 1);
    localparam logic [K2W-1:0] K2_MAX = K2W'(N2 - 1);

    // Step the coordinate pair, wrapping k1 into k2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k1 <= '0;
            k2 <= '0;
        end else if (clear) begin
            k1 <= '0;
            k2 <= '0;
        end else if (advance) begin
            if (k1 == K1_MAX) begin
                k1 <= '0;
                k2 <= (k2 == K2_MAX) ? '0 : k2 + K2W'(1);
            end else begin
                k1 <= k1 + K1W'(1);
            end
        end
    end

    // Final grid point flag
    always_comb last = (k1 == K1_MAX) && (k2 == K2_MAX);

endmodule

// File: rtl/pf_index_map.sv
// Module pf_index_map
// Combinational address generator. For a grid point it picks the combining
// rule from the raw sum N2*k1 + N1*k2 and produces both buffer addresses via
// (N2*a + N1*b) mod N, flagging operands whose mirrored coordinate equals
// N1 or N2 as zero. Assumes k1 < N1 and k2 < N2.
module pf_index_map #(
    parameter int N1  = 3,
    parameter int N2  = 4,
    parameter int K1W = 2,
    parameter int K2W = 2,
    parameter int AW  = 4
) (
    input  logic [K1W-1:0]      k1,
    input  logic [K2W-1:0]      k2,
    output pf_pkg::pf_branch_e  branch,
    output logic [AW-1:0]       addr_a,
    output logic [AW-1:0]       addr_b,
    output logic                zero_a,
    output logic                zero_b
);

    localparam int N  = N1 * N2;
    localparam int SW = pf_pkg::pf_bits(2 * N + 1);
    localparam logic [SW-1:0] SN  = SW'(N);
    localparam logic [SW-1:0] SN1 = SW'(N1);
    localparam logic [SW-1:0] SN2 = SW'(N2);

    // Modular linear index of a coordinate pair (a <= N1, b <= N2)
    function automatic logic [AW-1:0] lin(input logic [SW-1:0] a,
                                          input logic [SW-1:0] b);
        logic [SW-1:0] t;
        t = SN2 * a + SN1 * b;
        if (t >= SN) t = t - SN;
        if (t >= SN) t = t - SN;
        return t[AW-1:0];
    endfunction

    logic [SW-1:0] ka, kb, ma, mb, raw;

    // Widen coordinates and form mirrors and the raw sum
    always_comb begin
        ka  = SW'(k1);
        kb  = SW'(k2);
        ma  = SN1 - ka;
        mb  = SN2 - kb;
        raw = SN2 * ka + SN1 * kb;
    end

    // Select rule, addresses and zero flags
    always_comb begin
        if (raw >= SN) begin
            branch = pf_pkg::BR_SUM;
            addr_a = lin(ma, kb);
            zero_a = (ma == SN1);
            addr_b = lin(ka, mb);
            zero_b = (mb == SN2);
        end else begin
            branch = pf_pkg::BR_DIFF;
            addr_a = lin(ka, kb);
            zero_a = 1'b0;
            addr_b = lin(ma, mb);
            zero_b = (ma == SN1) || (mb == SN2);
        end
    end

endmodule

// File: rtl/pf_frame_buf.sv
// Module pf_frame_buf
// Register-based frame store with one write port and two combinational read
// ports. Entries reset to zero. Out-of-range addresses read zero and writes
// to them are dropped.
module pf_frame_buf #(
    parameter int DEPTH = 12,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wdata,
    input  logic [AW-1:0]        raddr_a,
    input  logic [AW-1:0]        raddr_b,
    output logic signed [DW-1:0] rdata_a,
    output logic signed [DW-1:0] rdata_b
);

    logic signed [DW-1:0] mem [DEPTH];

    // Store one sample per cycle, clear all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    // Two independent read ports
    always_comb begin
        rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
        rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;
    end

endmodule

// File: rtl/pf_combiner.sv
// Module pf_combiner
// Registered add/subtract of two signed operands with one guard bit, so the
// result never wraps. Zero flags force an operand to zero. Holds its output
// when not enabled.
module pf_combiner #(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  pf_pkg::pf_branch_e   branch,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic                 zero_a,
    input  logic                 zero_b,
    output logic signed [DW:0]   y
);

    logic signed [DW:0] ax, bx;

    // Sign-extend and mask operands
    always_comb begin
        ax = zero_a ? '0 : {a[DW-1], a};
        bx = zero_b ? '0 : {b[DW-1], b};
    end

    // Register the combined value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
        end else if (en) begin
            y <= (branch == pf_pkg::BR_SUM) ? ax + bx : ax - bx;
        end
    end

endmodule

// File: rtl/pf_precombiner.sv
// Module pf_precombiner (top)
// Prime-factor index mapper and pre-combiner. Holds one frame of N = N1*N2
// signed samples; on an accepted frame start it emits N combined values in
// column-major order, one per cycle, with a one-cycle registered latency.
// Assumes N1 and N2 are coprime. Writes and frame starts are ignored while
// busy.
module pf_precombiner #(
    parameter int N1 = 3,
    parameter int N2 = 4,
    parameter int DW = 8,
    localparam int N   = N1 * N2,
    localparam int AW  = pf_pkg::pf_bits(N),
    localparam int K1W = pf_pkg::pf_bits(N1),
    localparam int K2W = pf_pkg::pf_bits(N2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_data,
    output logic                 busy,
    output logic                 out_valid,
    output logic [K1W-1:0]       out_k1,
    output logic [K2W-1:0]       out_k2,
    output logic signed [DW:0]   out_data
);

    logic                 accept;
    logic                 buf_we;
    logic [K1W-1:0]       k1;
    logic [K2W-1:0]       k2;
    logic                 last;
    pf_pkg::pf_branch_e   branch;
    logic [AW-1:0]        addr_a, addr_b;
    logic                 zero_a, zero_b;
    logic signed [DW-1:0] rd_a, rd_b;

    // Gate frame start and writes on the busy state
    always_comb begin
        accept = frame_start && !busy;
        buf_we = wr_en && !busy;
    end

    // Busy state: set on accepted start, clear after the last grid point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end else if (busy && last) begin
            busy <= 1'b0;
        end
    end

    // Output strobe and coordinate tags, aligned with the combiner register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_k1    <= '0;
            out_k2    <= '0;
        end else begin
            out_valid <= busy;
            if (busy) begin
                out_k1 <= k1;
                out_k2 <= k2;
            end
        end
    end

    pf_coord_counter #(
        .N1 (N1), .N2 (N2), .K1W (K1W), .K2W (K2W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (busy),
        .k1      (k1),
        .k2      (k2),
        .last    (last)
    );

    pf_index_map #(
        .N1 (N1), .N2 (N2), .K1W (K1W), .K2W (K2W), .AW (AW)
    ) u_map (
        .k1     (k1),
        .k2     (k2),
        .branch (branch),
        .addr_a (addr_a),
        .addr_b (addr_b),
        .zero_a (zero_a),
        .zero_b (zero_b)
    );

    pf_frame_buf #(
        .DEPTH (N), .DW (DW), .AW (AW)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (buf_we),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (addr_a),
        .raddr_b (addr_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    pf_combiner #(
        .DW (DW)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (busy),
        .branch (branch),
        .a      (rd_a),
        .b      (rd_b),
        .zero_a (zero_a),
        .zero_b (zero_b),
        .y      (out_data)
    );

endmodule

// File: rtl/pf_precombiner_chk.sv
// Module pf_precombiner_chk
// Protocol checker for pf_precombiner: frame acceptance, emission length
// and column-major ordering. Attached to the top with bind below.
module pf_precombiner_chk #(
    parameter int N1  = 3,
    parameter int N2  = 4,
    parameter int K1W = 2,
    parameter int K2W = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_start,
    input logic           busy,
    input logic           out_valid,
    input logic [K1W-1:0] out_k1,
    input logic [K2W-1:0] out_k2
);

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !busy |=> busy);                                   // R6

    AST_FALL_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid && out_k1 == K1W'(N1 - 1)
                        && out_k2 == K2W'(N2 - 1));                       // R6

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));                                       // R2

    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> out_valid);                               // R2

    AST_FIRST_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(out_valid) |-> out_k1 == '0 && out_k2 == '0); // R2

    AST_COLUMN_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) && out_k1 != '0
        |-> out_k1 == $past(out_k1) + K1W'(1) && out_k2 == $past(out_k2)); // R2

endmodule

bind pf_precombiner pf_precombiner_chk #(
    .N1 (N1), .N2 (N2), .K1W (K1W), .K2W (K2W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .busy        (busy),
    .out_valid   (out_valid),
    .out_k1      (out_k1),
    .out_k2      (out_k2)
);

// File: tb/pf_precombiner_test.sv
`timescale 1ns/1ps
// Bench for pf_precombiner: a behavioural cycle model (integer frame copy,
// queue of pending outputs) compared against the design on every clock.
module pf_precombiner_test;

    localparam int N1 = 3;
    localparam int N2 = 4;
    localparam int DW = 8;
    localparam int N  = N1 * N2;
    localparam int AW = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frame_start = 1'b0;
    logic                 wr_en = 1'b0;
    logic [AW-1:0]        wr_addr = '0;
    logic signed [DW-1:0] wr_data = '0;
    logic                 busy, out_valid;
    logic [1:0]           out_k1, out_k2;
    logic signed [DW:0]   out_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pf_precombiner #(.N1(N1), .N2(N2), .DW(DW)) uut (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .busy (busy), .out_valid (out_valid), .out_k1 (out_k1),
        .out_k2 (out_k2), .out_data (out_data)
    );

    typedef struct {
        int    y;
        int    k1;
        int    k2;
        string tag;
    } exp_t;

    int   mbuf [N];
    exp_t pending [$];
    bit   m_busy, m_valid;
    int   m_cnt;
    exp_t m_out;

    // Sample at a mapped pair; a mirror equal to N1 or N2 reads zero (R5)
    function automatic int smp(int a, int b);
        if (a == N1 || b == N2) return 0;
        return mbuf[(N2 * a + N1 * b) % N];
    endfunction

    // Expected combined value and the requirement tag it exercises
    function automatic exp_t expect_at(int k1, int k2);
        exp_t e;
        e.k1 = k1;
        e.k2 = k2;
        if (N2 * k1 + N1 * k2 < N) begin
            e.y   = smp(k1, k2) - smp(N1 - k1, N2 - k2);
            e.tag = "R3";
        end else begin
            e.y   = smp(N1 - k1, k2) + smp(k1, N2 - k2);
            e.tag = "R4";
        end
        if (k1 == 0 || k2 == 0) e.tag = {e.tag, "/R5"};
        return e;
    endfunction

    // Cycle model of the acceptance rules (R6, R7) and output timing (R2)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy  = 1'b0;
            m_valid = 1'b0;
            m_cnt   = 0;
            foreach (mbuf[i]) mbuf[i] = 0;
            pending.delete();
        end else begin
            if (wr_en && !m_busy) mbuf[int'(wr_addr)] = int'(wr_data);
            m_valid = m_busy;
            if (m_busy) begin
                m_out = pending.pop_front();
                m_cnt = m_cnt + 1;
                if (m_cnt == N) m_busy = 1'b0;
            end else if (frame_start) begin
                m_busy = 1'b1;
                m_cnt  = 0;
                for (int k2 = 0; k2 < N2; k2++)
                    for (int k1 = 0; k1 < N1; k1++)
                        pending.push_back(expect_at(k1, k2));
            end
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6", "busy", int'(busy), int'(m_busy));
            check("R2", "out_valid", int'(out_valid), int'(m_valid));
            if (m_valid && out_valid) begin
                check("R2", "out_k1", int'(out_k1), m_out.k1);
                check("R2", "out_k2", int'(out_k2), m_out.k2);
                check({m_out.tag, "/R8"}, "out_data", int'(out_data), m_out.y);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hang counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_data after reset", int'(out_data), 0);

        // R1: frame from a freshly reset buffer is all zeros
        pulse_start();
        wait_idle();

        // R3/R4/R5: ramp pattern
        for (int i = 0; i < N; i++) wr(i, 13 * i - 70);
        pulse_start();
        // R7: writes during emission are ignored; R6: repeated start ignored
        wr(0, 99);
        wr(7, -99);
        pulse_start();
        wait_idle();
        // R7: next frame must still see the ramp values
        pulse_start();
        wait_idle();

        // R8: extreme values, last write together with an accepted start (R7)
        for (int i = 0; i < N - 1; i++) wr(i, (i % 2 == 0) ? 127 : -128);
        @(negedge clk);
        frame_start = 1'b1;
        wr_en       = 1'b1;
        wr_addr     = AW'(N - 1);
        wr_data     = DW'(127);
        @(negedge clk);
        frame_start = 1'b0;
        wr_en       = 1'b0;
        wait_idle();

        // R8: all maximum, then all minimum
        for (int i = 0; i < N; i++) wr(i, 127);
        pulse_start();
        wait_idle();
        for (int i = 0; i < N; i++) wr(i, -128);
        pulse_start();
        wait_idle();

        // Random frames, the second started right as busy falls (R6)
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < N; i++) wr(i, int'($urandom_range(255)) - 128);
            pulse_start();
            @(negedge clk);
            while (busy) @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            wait_idle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule